// File: doc/BRIEF.md
# Safety Operating-Mode Controller

This block is the mode sequencer of a single-channel fail-safe unit. After power-on reset it waits in a boot mode for the outcome of the permanent-fault self-tests. It enters the running mode only if every test reports a pass. From the running mode, software may open a configuration session and close it again. Test failures, a missing test outcome, or a fault that proves to be permanent all send the controller to a latched safe mode. That mode drives the exclusion output, which switches the display off.

A runtime error reported in the running or configuration mode does not latch the safe mode at once. The controller first enters a suspect phase. There it raises a restart request to the channel and waits until the channel reports that the restart has finished. It then watches the error input for a fixed observation window. A recurrence inside the window marks the fault as permanent and selects the safe mode. A quiet window marks the fault as transient, and the controller returns to the running mode.

The outcome of the self-tests arrives as a valid strobe with one pass bit per test. The number of tests, the boot time-out, the restart time-out and the observation window are parameters.

Top module: `safety_mode_ctrl`

## Requirements
- R1: The mode output is encoded as 0 boot, 1 running, 2 configuration, 3 suspect and 4 safe. While reset is held low, and on release of reset, the mode is boot, the restart request is low and the exclusion output is low.
- R2: In boot mode, a cycle with the result strobe high and every pass bit set moves the controller to running mode on the next clock. A strobe with any pass bit clear moves it to safe mode.
- R3: If no result strobe arrives within STARTUP_TMO cycles of boot mode, the controller enters safe mode. The error input and the configuration request have no effect in boot mode.
- R4: A configuration request moves running mode to configuration mode, and a done pulse returns configuration mode to running mode. A configuration request in any other mode has no effect, and configuration mode is entered from no mode other than running.
- R5: An error detected in running or configuration mode moves the controller to suspect mode with the restart request high. The error wins over a configuration request or done pulse in the same cycle.
- R6: The restart request stays high until the restart-done input is seen. While it is high, the error input is ignored.
- R7: If restart-done does not arrive within RESTART_TMO cycles of the restart request, the controller enters safe mode.
- R8: After restart-done, the controller stays in suspect mode with the restart request low. An error in any of the following WINDOW cycles, including the first and the last, moves it to safe mode.
- R9: If WINDOW cycles pass after restart-done without an error, the controller returns to running mode, which clears the suspect indication.
- R10: Safe mode holds until reset. In safe mode the exclusion output stays high, the restart request stays low, and every other input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| st_valid_i | input | 1 | Self-test results are valid this cycle |
| st_pass_i | input | N_TESTS | One pass bit per self-test |
| cfg_req_i | input | 1 | Request to open a configuration session |
| cfg_done_i | input | 1 | Configuration session finished |
| err_det_i | input | 1 | Runtime error detected by periodic tests or time-out checks |
| restart_done_i | input | 1 | Channel has completed the requested restart |
| mode_o | output | 3 | Current operating mode (encoding in R1) |
| restart_req_o | output | 1 | Restart request to the channel |
| safe_off_o | output | 1 | Exclusion output, high in safe mode |

## Verification
The bench aims at the edges of each timed phase. It places an error in the first and in the last cycle of the observation window. A design with an off-by-one window would return to running mode on the last-cycle error, or would miss the first-cycle one. It lets the boot and restart time-outs expire exactly. A counter that was not cleared on mode change would fire early or late there. It also sends error pulses during the restart phase and during boot, which a design lacking those filters would turn into a premature safe state. It applies coincident error and configuration events, which a design with the wrong priority would resolve into configuration instead of suspect. Finally, it pokes every input while in safe mode to show that the state is truly absorbing.

// File: rtl/smc_pkg.sv
// Package: shared state type and mode codes for the safety mode controller.
// Assumes: mode codes are consumed by external logic and must stay fixed.
package smc_pkg;

    typedef enum logic [2:0] {
        ST_BOOT    = 3'd0,
        ST_RUN     = 3'd1,
        ST_CFG     = 3'd2,
        ST_RESTART = 3'd3,
        ST_SAFE    = 3'd4,
        ST_OBSERVE = 3'd5
    } state_e;

    localparam logic [2:0] MODE_BOOT = 3'd0;
    localparam logic [2:0] MODE_RUN  = 3'd1;
    localparam logic [2:0] MODE_CFG  = 3'd2;
    localparam logic [2:0] MODE_SUS  = 3'd3;
    localparam logic [2:0] MODE_SAFE = 3'd4;

    // Map an internal state onto the externally visible mode code.
    function automatic logic [2:0] mode_of(state_e s);
        case (s)
            ST_BOOT:               return MODE_BOOT;
            ST_RUN:                return MODE_RUN;
            ST_CFG:                return MODE_CFG;
            ST_RESTART,
            ST_OBSERVE:            return MODE_SUS;
            default:               return MODE_SAFE;
        endcase
    endfunction

endpackage

// File: rtl/smc_test_gate.sv
// Module: combines the per-test pass bits into a single verdict.
// Assumes: pass bits are meaningful only while valid_i is high.
module smc_test_gate #(
    parameter int N_TESTS = 3
) (
    input  logic               valid_i,
    input  logic [N_TESTS-1:0] pass_i,
    output logic               ok_o,
    output logic               fail_o
);

    logic [N_TESTS:0] chain;

    assign chain[0] = 1'b1;

    // AND chain over all tests, one stage per test.
    for (genvar g = 0; g < N_TESTS; g++) begin : g_and
        assign chain[g+1] = chain[g] & pass_i[g];
    end

    // Verdict is only produced while the results are valid.
    always_comb begin
        ok_o   = valid_i &  chain[N_TESTS];
        fail_o = valid_i & ~chain[N_TESTS];
    end

endmodule

// File: rtl/smc_dwell_timer.sv
// Module: counts cycles spent in the current state, saturating at MAX.
// Assumes: clear_i is high in the cycle before a state change.
module smc_dwell_timer #(
    parameter int MAX = 64,
    localparam int W  = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] TOP = W'(MAX);

    // Dwell counter: restarts on state change, otherwise counts up to TOP.
    always_ff @(posedge clk) begin
        if (!rst_n)               count_o <= '0;
        else if (clear_i)         count_o <= '0;
        else if (count_o != TOP)  count_o <= count_o + 1'b1;
    end

endmodule

// File: rtl/smc_mode_fsm.sv
// Module: mode sequencer with suspect phase (restart, then observation window).
// Assumes: inputs are synchronous to clk; the time-outs are at least 1.
module smc_mode_fsm
    import smc_pkg::*;
#(
    parameter int STARTUP_TMO = 1000,
    parameter int RESTART_TMO = 64,
    parameter int WINDOW      = 32,
    localparam int MAXL = (STARTUP_TMO > RESTART_TMO)
                          ? ((STARTUP_TMO > WINDOW) ? STARTUP_TMO : WINDOW)
                          : ((RESTART_TMO > WINDOW) ? RESTART_TMO : WINDOW),
    localparam int CW   = $clog2(MAXL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_ok_i,
    input  logic          st_fail_i,
    input  logic          cfg_req_i,
    input  logic          cfg_done_i,
    input  logic          err_det_i,
    input  logic          restart_done_i,
    input  logic [CW-1:0] dwell_i,
    output logic          dwell_clr_o,
    output logic [2:0]    mode_o,
    output logic          restart_req_o,
    output logic          safe_off_o
);

    localparam logic [CW-1:0] BOOT_LAST = CW'(STARTUP_TMO - 1);
    localparam logic [CW-1:0] RST_LAST  = CW'(RESTART_TMO - 1);
    localparam logic [CW-1:0] WIN_LAST  = CW'(WINDOW - 1);

    state_e state_q, state_d;

    // Next-state selection; error events take priority over configuration.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: begin
                if (st_fail_i)                  state_d = ST_SAFE;
                else if (st_ok_i)               state_d = ST_RUN;
                else if (dwell_i == BOOT_LAST)  state_d = ST_SAFE;
            end
            ST_RUN: begin
                if (err_det_i)                  state_d = ST_RESTART;
                else if (cfg_req_i)             state_d = ST_CFG;
            end
            ST_CFG: begin
                if (err_det_i)                  state_d = ST_RESTART;
                else if (cfg_done_i)            state_d = ST_RUN;
            end
            ST_RESTART: begin
                if (restart_done_i)             state_d = ST_OBSERVE;
                else if (dwell_i == RST_LAST)   state_d = ST_SAFE;
            end
            ST_OBSERVE: begin
                if (err_det_i)                  state_d = ST_SAFE;
                else if (dwell_i == WIN_LAST)   state_d = ST_RUN;
            end
            default:                            state_d = ST_SAFE;
        endcase
    end

    // State register, boot mode after power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Outputs decoded from the registered state.
    always_comb begin
        dwell_clr_o   = (state_d != state_q);
        mode_o        = mode_of(state_q);
        restart_req_o = (state_q == ST_RESTART);
        safe_off_o    = (state_q == ST_SAFE);
    end

    // Marks cycles for which $past refers to a post-reset value.
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_safe_absorbing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAFE) |=> (state_q == ST_SAFE && safe_off_o && !restart_req_o));

    p_run_needs_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state_q == ST_RUN && $past(state_q) == ST_BOOT) |-> $past(st_ok_i));

    p_cfg_only_from_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state_q == ST_CFG && $past(state_q) != ST_CFG)
        |-> ($past(state_q) == ST_RUN));

    p_restart_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_req_o && !restart_done_i)
        |=> (restart_req_o || state_q == ST_SAFE));

    p_window_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state_q == ST_RUN && $past(state_q) == ST_OBSERVE)
        |-> ($past(dwell_i) == WIN_LAST));

endmodule

// File: rtl/safety_mode_ctrl.sv
// Module: top of the safety operating-mode controller.
// Assumes: self-test results arrive as a single valid cycle with all pass bits.
module safety_mode_ctrl #(
    parameter int N_TESTS     = 3,
    parameter int STARTUP_TMO = 1000,
    parameter int RESTART_TMO = 64,
    parameter int WINDOW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_valid_i,
    input  logic [N_TESTS-1:0] st_pass_i,
    input  logic               cfg_req_i,
    input  logic               cfg_done_i,
    input  logic               err_det_i,
    input  logic               restart_done_i,
    output logic [2:0]         mode_o,
    output logic               restart_req_o,
    output logic               safe_off_o
);

    localparam int MAXL = (STARTUP_TMO > RESTART_TMO)
                          ? ((STARTUP_TMO > WINDOW) ? STARTUP_TMO : WINDOW)
                          : ((RESTART_TMO > WINDOW) ? RESTART_TMO : WINDOW);
    localparam int CW   = $clog2(MAXL + 1);

    logic          st_ok, st_fail, dwell_clr;
    logic [CW-1:0] dwell;

    smc_test_gate #(.N_TESTS(N_TESTS)) u_gate (
        .valid_i (st_valid_i),
        .pass_i  (st_pass_i),
        .ok_o    (st_ok),
        .fail_o  (st_fail)
    );

    smc_dwell_timer #(.MAX(MAXL)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (dwell_clr),
        .count_o (dwell)
    );

    smc_mode_fsm #(
        .STARTUP_TMO (STARTUP_TMO),
        .RESTART_TMO (RESTART_TMO),
        .WINDOW      (WINDOW)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .st_ok_i        (st_ok),
        .st_fail_i      (st_fail),
        .cfg_req_i      (cfg_req_i),
        .cfg_done_i     (cfg_done_i),
        .err_det_i      (err_det_i),
        .restart_done_i (restart_done_i),
        .dwell_i        (dwell),
        .dwell_clr_o    (dwell_clr),
        .mode_o         (mode_o),
        .restart_req_o  (restart_req_o),
        .safe_off_o     (safe_off_o)
    );

endmodule

// File: tb/tb_safety_mode_ctrl.sv
module tb_safety_mode_ctrl;

    localparam int NT   = 3;
    localparam int BTMO = 10;
    localparam int RTMO = 5;
    localparam int WIN  = 4;

    localparam logic [2:0] M_BOOT = 3'd0, M_RUN = 3'd1, M_CFG = 3'd2,
                           M_SUS  = 3'd3, M_SAFE = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [NT-1:0] st_pass = '0;
    logic          cfg_req = 1'b0, cfg_done = 1'b0, err_det = 1'b0, rdone = 1'b0;
    logic [2:0]    mode;
    logic          rreq, safe;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [2:0] mode;
        logic       rreq;
        logic       safe;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    safety_mode_ctrl #(
        .N_TESTS(NT), .STARTUP_TMO(BTMO), .RESTART_TMO(RTMO), .WINDOW(WIN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .st_valid_i(st_valid), .st_pass_i(st_pass),
        .cfg_req_i(cfg_req), .cfg_done_i(cfg_done), .err_det_i(err_det),
        .restart_done_i(rdone), .mode_o(mode), .restart_req_o(rreq),
        .safe_off_o(safe)
    );

    // Monitor: after each edge, compare outputs with the oldest expectation.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (mode !== e.mode || rreq !== e.rreq || safe !== e.safe) begin
                n_bad++;
                $display("FAIL %s: got mode=%0d req=%0b safe=%0b, expected mode=%0d req=%0b safe=%0b",
                         e.tag, mode, rreq, safe, e.mode, e.rreq, e.safe);
            end
        end
    end

    // Driver: inputs already set at this negedge; queue the result after the edge.
    task automatic step(input logic [2:0] m, input logic r, input logic s, input string tag);
        exp_t e;
        e.mode = m; e.rreq = r; e.safe = s; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        st_valid = 1'b0; st_pass = '0; cfg_req = 1'b0;
        cfg_done = 1'b0; err_det = 1'b0; rdone = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        st_valid = 1'b0; st_pass = '0; cfg_req = 1'b0;
        cfg_done = 1'b0; err_det = 1'b0; rdone = 1'b0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (mode !== M_BOOT || rreq !== 1'b0 || safe !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got mode=%0d req=%0b safe=%0b, expected mode=0 req=0 safe=0",
                     mode, rreq, safe);
        end
        rst_n = 1'b1;
    endtask

    task automatic boot_ok();
        st_valid = 1'b1; st_pass = '1;
        step(M_RUN, 1'b0, 1'b0, "R2 all pass");
    endtask

    initial begin
        // Scenario A: main path through configuration, suspect and safe.
        do_reset();
        boot_ok();
        cfg_req = 1'b1;  step(M_CFG, 0, 0, "R4 enter cfg");
        cfg_req = 1'b1;  step(M_CFG, 0, 0, "R4 req in cfg ignored");
        cfg_done = 1'b1; step(M_RUN, 0, 0, "R4 done");
        cfg_done = 1'b1; step(M_RUN, 0, 0, "R4 done in run ignored");
        err_det = 1'b1; cfg_req = 1'b1; step(M_SUS, 1, 0, "R5 err beats cfg_req");
        err_det = 1'b1;  step(M_SUS, 1, 0, "R6 err ignored in restart");
        step(M_SUS, 1, 0, "R6 hold");
        step(M_SUS, 1, 0, "R6 hold");
        rdone = 1'b1;    step(M_SUS, 0, 0, "R8 observe");
        for (int i = 0; i < WIN - 1; i++) step(M_SUS, 0, 0, "R9 window");
        step(M_RUN, 0, 0, "R9 back to run");
        cfg_req = 1'b1;  step(M_CFG, 0, 0, "R4 enter cfg again");
        err_det = 1'b1; cfg_done = 1'b1; step(M_SUS, 1, 0, "R5 err beats done");
        rdone = 1'b1;    step(M_SUS, 0, 0, "R8 observe");
        for (int i = 0; i < WIN - 1; i++) step(M_SUS, 0, 0, "R8 window");
        err_det = 1'b1;  step(M_SAFE, 0, 1, "R8 err in last window cycle");
        cfg_req = 1'b1;  step(M_SAFE, 0, 1, "R10 cfg ignored");
        rdone = 1'b1; err_det = 1'b1; step(M_SAFE, 0, 1, "R10 restart ignored");
        st_valid = 1'b1; st_pass = '1; step(M_SAFE, 0, 1, "R10 pass ignored");
        step(M_SAFE, 0, 1, "R10 held");

        // Scenario B: one failing self-test.
        do_reset();
        st_valid = 1'b1; st_pass = 3'b101; step(M_SAFE, 0, 1, "R2 one fail");
        step(M_SAFE, 0, 1, "R10 held");

        // Scenario C: boot time-out, with ignored error and request.
        do_reset();
        err_det = 1'b1;  step(M_BOOT, 0, 0, "R3 err ignored in boot");
        cfg_req = 1'b1;  step(M_BOOT, 0, 0, "R4 req ignored in boot");
        for (int i = 2; i < BTMO - 1; i++) step(M_BOOT, 0, 0, "R3 waiting");
        step(M_SAFE, 0, 1, "R3 boot timeout");

        // Scenario D: restart time-out.
        do_reset();
        boot_ok();
        err_det = 1'b1;  step(M_SUS, 1, 0, "R5 err in run");
        for (int i = 0; i < RTMO - 1; i++) step(M_SUS, 1, 0, "R7 waiting");
        step(M_SAFE, 0, 1, "R7 restart timeout");

        // Scenario E: recurrence in the first observation cycle.
        do_reset();
        boot_ok();
        err_det = 1'b1;  step(M_SUS, 1, 0, "R5 err in run");
        rdone = 1'b1;    step(M_SUS, 0, 0, "R8 observe");
        err_det = 1'b1;  step(M_SAFE, 0, 1, "R8 err in first window cycle");

        // Scenario F: success at the last boot cycle.
        do_reset();
        for (int i = 0; i < BTMO - 1; i++) step(M_BOOT, 0, 0, "R3 waiting");
        st_valid = 1'b1; st_pass = '1; step(M_RUN, 0, 0, "R2 pass at last boot cycle");

        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule